// File: doc/BRIEF.md
# Character Dot Serializer with Soft Glyphs

This block turns a character code and the scan-line number inside the current character row into a stream of monochrome pixels for a text display. A character strobe selects the glyph row and loads it. Codes with the top bit clear read a fixed 128-glyph pattern table. Codes with the top bit set read a 2 KB glyph RAM that the host fills through a simple write port. The chosen 8-bit row is widened, so that every lit dot also lights the pixel to its right. A shift register then sends the row out one pixel per dot clock across a 12-pixel cell.

Only the first 8 pixels of a cell advance the pattern. Pixels 9 to 12 repeat the last bit, so a dot in the rightmost column carries on across the gap to the next character. A blank input darkens the output at any time. Raster timing, attributes, cursor and colour are generated elsewhere. The surrounding timing generator pulses the strobe once every 12 dot clocks and drives blank outside the active area.

The sequencer has three states:
- `SER_IDLE` means no cell is in flight, and the output is dark.
- `SER_DOTS` covers pixels 1 to 8, and the pattern shifts after each of them.
- `SER_TAIL` covers pixels 9 to 12, and the pattern is held.

The transitions are:
- LOAD: a strobe in any state, which goes to `SER_DOTS` with the counter cleared.
- DOTS_DONE: `SER_DOTS` with the count at 7, which goes to `SER_TAIL`.
- CELL_DONE: `SER_TAIL` with the count at 11, which goes to `SER_IDLE`.

Top module: `glyph_dot_serializer`

## Requirements
- R1: While reset is held and after reset is released, with no strobe, `pixel` is 0.
- R2: When `char_code[7]` is 1, the row comes from glyph RAM at 11-bit address `{char_code[6:0], line_num[3:0]}`.
- R3: When `char_code[7]` is 0, the row comes from the fixed table at address `{line_num[3:0], char_code[6:0]}`. The row stored for code c and line l is `((c*29 + l*71) mod 256) XOR 0xA5`.
- R4: The 9-bit pattern is `{1'b0,row} | {row,1'b0}`, so every lit dot also lights the next pixel to the right.
- R5: Pixel n of a cell, for n from 1 to 8, is pattern bit 9-n. Pixels 9 to 12 all equal pattern bit 0. A lit pixel is 1.
- R6: A strobe sampled at clock edge k loads the row. Pixel 1 is on `pixel` in the cycle after edge k, and pixel n is there n-1 cycles later. After pixel 12 the output is 0 until the next strobe. A strobe in the middle of a cell abandons that cell and starts the new one.
- R7: While `blank` is 1, `pixel` is 0 in the same cycle, whatever the pattern holds.
- R8: A host write with `host_we` = 1 and `host_addr` between 0x8000 and 0x87FF stores `host_wdata` at glyph RAM address `host_addr[10:0]`. Writes outside that window change nothing.
- R9: A host write changes no cell already loaded. A fetch on the same edge as a write to the same address returns the old row, and the next fetch returns the new row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low reset |
| char_strobe | input | 1 | Loads a new cell from the code and the line number |
| char_code | input | 8 | Character code; bit 7 selects the glyph RAM |
| line_num | input | 4 | Scan line inside the character row |
| blank | input | 1 | Forces the output dark |
| host_we | input | 1 | Host write enable for glyph RAM |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| pixel | output | 1 | Serial pixel, 1 = lit |

## Verification
The bench builds the block with its default parameters: an 8-bit code, a 4-bit line number, an 8-dot row and a 12-pixel cell. Because the address space is only 11 bits, every one of the 2048 RAM locations can be filled with a computed value. It also allows a sweep over all 256 codes and all 16 lines, with each of the 12 pixels of every cell compared against an arithmetic model. Directed cells then cover the edge patterns of the widening and the tail, writes outside the window, blanking in the middle of a cell, a restart in the middle of a cell, and a write on the same edge as a fetch.

// File: rtl/glyph_ser_pkg.sv
package glyph_ser_pkg;

    typedef enum logic [1:0] {
        SER_IDLE = 2'd0,
        SER_DOTS = 2'd1,
        SER_TAIL = 2'd2
    } ser_state_e;

    // Fixed glyph table contents, computed from the address {line, code}.
    function automatic logic [7:0] fixed_row(input logic [10:0] addr);
        logic [7:0] ln;
        logic [7:0] cd;
        logic [7:0] sum;
        ln  = {4'd0, addr[10:7]};
        cd  = {1'b0, addr[6:0]};
        sum = cd * 8'd29 + ln * 8'd71;
        return sum ^ 8'hA5;
    endfunction

endpackage

// File: rtl/glyph_rom.sv
module glyph_rom #(
    parameter int ADDR_W = 11,
    parameter int ROW_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row
);
    import glyph_ser_pkg::*;

    always_comb begin
        row = ROW_W'(fixed_row(11'(addr)));
    end
endmodule

// File: rtl/glyph_ram.sv
module glyph_ram #(
    parameter int ADDR_W = 11,
    parameter int ROW_W  = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ROW_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ROW_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ROW_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // The read is taken before this edge's write lands, so a fetch on the
    // same edge as a write sees the old row.
    assign rdata = mem[raddr];
endmodule

// File: rtl/glyph_dot_shifter.sv
module glyph_dot_shifter #(
    parameter int ROW_W  = 8,
    parameter int CELL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] row,
    input  logic             blank,
    output logic             pixel
);
    import glyph_ser_pkg::*;

    localparam int PAT_W = ROW_W + 1;
    localparam int CNT_W = $clog2(CELL_W);
    localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(ROW_W - 1);
    localparam logic [CNT_W-1:0] LAST_PIX   = CNT_W'(CELL_W - 1);

    ser_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PAT_W-1:0] pat_q;
    logic [PAT_W-1:0] widened;

    assign widened = {1'b0, row} | {row, 1'b0};

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SER_IDLE: st_d = SER_IDLE;
            SER_DOTS: if (cnt_q == LAST_SHIFT) st_d = SER_TAIL;
            SER_TAIL: if (cnt_q == LAST_PIX)   st_d = SER_IDLE;
            default:  st_d = SER_IDLE;
        endcase
        if (load) begin
            st_d = SER_DOTS;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SER_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Output datapath: counter and pattern register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pat_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            pat_q <= widened;
        end else begin
            unique case (st_q)
                SER_IDLE: cnt_q <= '0;
                SER_DOTS: begin
                    cnt_q <= cnt_q + 1'b1;
                    pat_q <= pat_q << 1;
                end
                SER_TAIL: cnt_q <= (cnt_q == LAST_PIX) ? '0 : cnt_q + 1'b1;
                default:  cnt_q <= '0;
            endcase
        end
    end

    assign pixel = (st_q != SER_IDLE) && pat_q[PAT_W-1] && !blank;
endmodule

// File: rtl/glyph_dot_serializer.sv
module glyph_dot_serializer #(
    parameter int              CODE_W    = 8,
    parameter int              LINE_W    = 4,
    parameter int              ROW_W     = 8,
    parameter int              CELL_W    = 12,
    parameter int              HOST_AW   = 16,
    parameter logic [15:0]     HOST_BASE = 16'h8000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               char_strobe,
    input  logic [CODE_W-1:0]  char_code,
    input  logic [LINE_W-1:0]  line_num,
    input  logic               blank,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [ROW_W-1:0]   host_wdata,
    output logic               pixel
);
    localparam int IDX_W   = CODE_W - 1;
    localparam int GADDR_W = IDX_W + LINE_W;

    logic [GADDR_W-1:0] rom_addr;
    logic [GADDR_W-1:0] ram_raddr;
    logic [ROW_W-1:0]   rom_row;
    logic [ROW_W-1:0]   ram_row;
    logic [ROW_W-1:0]   sel_row;
    logic               host_hit;
    logic [HOST_AW-1:0] base_addr;

    assign base_addr = HOST_AW'(HOST_BASE);
    assign host_hit  = host_we &&
                       (host_addr[HOST_AW-1:GADDR_W] == base_addr[HOST_AW-1:GADDR_W]);

    // Fixed table: line number is the high part of the address.
    assign rom_addr  = {line_num, char_code[IDX_W-1:0]};
    // Soft glyphs: code is the high part of the address.
    assign ram_raddr = {char_code[IDX_W-1:0], line_num};

    glyph_rom #(.ADDR_W(GADDR_W), .ROW_W(ROW_W)) u_rom (
        .addr (rom_addr),
        .row  (rom_row)
    );

    glyph_ram #(.ADDR_W(GADDR_W), .ROW_W(ROW_W)) u_ram (
        .clk   (clk),
        .we    (host_hit),
        .waddr (host_addr[GADDR_W-1:0]),
        .wdata (host_wdata),
        .raddr (ram_raddr),
        .rdata (ram_row)
    );

    assign sel_row = char_code[CODE_W-1] ? ram_row : rom_row;

    glyph_dot_shifter #(.ROW_W(ROW_W), .CELL_W(CELL_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (char_strobe),
        .row   (sel_row),
        .blank (blank),
        .pixel (pixel)
    );
endmodule

// File: rtl/glyph_ser_chk.sv
module glyph_ser_chk
    import glyph_ser_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int CELL_W = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       load,
    input logic                       blank,
    input logic                       pixel,
    input ser_state_e                 st_q,
    input logic [$clog2(CELL_W)-1:0]  cnt_q,
    input logic [ROW_W:0]             pat_q
);
    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> !pixel); // R7

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SER_IDLE) |-> !pixel); // R6

    AST_LOAD_STARTS_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q == SER_DOTS && cnt_q == '0)); // R6

    AST_CNT_IN_CELL: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < CELL_W); // R6

    AST_DOTS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SER_DOTS && !load) |=> (pat_q == (ROW_W+1)'($past(pat_q) << 1))); // R5

    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SER_TAIL && !load) |=> $stable(pat_q)); // R5
endmodule

bind glyph_dot_shifter glyph_ser_chk #(.ROW_W(ROW_W), .CELL_W(CELL_W)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .blank (blank),
    .pixel (pixel),
    .st_q  (st_q),
    .cnt_q (cnt_q),
    .pat_q (pat_q)
);

// File: tb/test_glyph_dot_serializer.sv
module test_glyph_dot_serializer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_strobe = 1'b0;
    logic [7:0]  char_code = '0;
    logic [3:0]  line_num = '0;
    logic        blank = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        pixel;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_ram [2048];

    always #10 clk = ~clk;

    glyph_dot_serializer i_glyph_dot_serializer (
        .clk (clk), .rst_n (rst_n), .char_strobe (char_strobe),
        .char_code (char_code), .line_num (line_num), .blank (blank),
        .host_we (host_we), .host_addr (host_addr), .host_wdata (host_wdata),
        .pixel (pixel)
    );

    function automatic logic [7:0] fill_val(input int a);
        return 8'((a * 7) ^ (a >> 3)) ^ 8'h3C;
    endfunction

    function automatic logic [7:0] rom_exp(input int c, input int l);
        return 8'(c * 29 + l * 71) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] row_exp(input logic [7:0] c, input logic [3:0] l);
        if (c[7]) return exp_ram[{c[6:0], l}];
        return rom_exp(int'(c[6:0]), int'(l));
    endfunction

    function automatic logic pix_exp(input logic [7:0] r, input int n);
        logic [8:0] p;
        p = {1'b0, r} | {r, 1'b0};
        if (n <= 8) return p[9 - n];
        return p[0];
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: pixel=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // Caller stands at a negedge.
    task automatic start_char(input logic [7:0] c, input logic [3:0] l);
        char_strobe = 1'b1;
        char_code   = c;
        line_num    = l;
    endtask

    task automatic cell_pixels(input logic [7:0] r, input int first, input int last,
                               input string req);
        for (int n = first; n <= last; n++) begin
            @(negedge clk);
            char_strobe = 1'b0;
            host_we     = 1'b0;
            check(pixel, blank ? 1'b0 : pix_exp(r, n), req);
        end
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check(pixel, 1'b0, "R1");
        end
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(pixel, 1'b0, "R1");
        end

        // R8: fill every glyph RAM location through the window
        for (int a = 0; a < 2048; a++) begin
            exp_ram[a] = fill_val(a);
            host_write(16'h8000 + 16'(a), fill_val(a));
        end
        // R8: writes just outside the window must change nothing
        host_write(16'h8805, ~fill_val(5));
        host_write(16'h7FFF, ~fill_val(2047));

        // R2 / R3: all codes by all lines, back to back
        for (int c = 0; c < 256; c++) begin
            for (int l = 0; l < 16; l++) begin
                start_char(8'(c), 4'(l));
                cell_pixels(row_exp(8'(c), 4'(l)), 1, 12, (c >= 128) ? "R2" : "R3");
            end
        end
        // R6: dark after the last cell
        repeat (3) begin
            @(negedge clk);
            check(pixel, 1'b0, "R6");
        end

        // R8: aliased locations still hold the in-window data
        start_char(8'h80, 4'd5);
        cell_pixels(fill_val(5), 1, 12, "R8");
        start_char(8'hFF, 4'd15);
        cell_pixels(fill_val(2047), 1, 12, "R8");

        // R4: a single dot in the last column widens into the tail
        @(negedge clk);
        exp_ram[12'h010] = 8'h01;
        host_write(16'h8010, 8'h01);
        start_char(8'h81, 4'd0);
        cell_pixels(8'h01, 1, 12, "R4");
        // R5: a single dot in the first column lights pixels 1 and 2 only
        exp_ram[12'h020] = 8'h80;
        @(negedge clk);
        host_write(16'h8020, 8'h80);
        start_char(8'h82, 4'd0);
        cell_pixels(8'h80, 1, 12, "R5");

        // R7: blank in the middle of a solid row
        exp_ram[12'h030] = 8'hFF;
        @(negedge clk);
        host_write(16'h8030, 8'hFF);
        start_char(8'h83, 4'd0);
        cell_pixels(8'hFF, 1, 2, "R7");
        blank = 1'b1;
        cell_pixels(8'hFF, 3, 6, "R7");
        blank = 1'b0;
        cell_pixels(8'hFF, 7, 12, "R7");

        // R6: restart in the middle of a cell
        start_char(8'h83, 4'd0);
        cell_pixels(8'hFF, 1, 5, "R6");
        start_char(8'h82, 4'd0);
        cell_pixels(8'h80, 1, 12, "R6");

        // R9: a write during display does not reach the loaded cell
        exp_ram[12'h1A7] = 8'h81;
        @(negedge clk);
        host_write(16'h81A7, 8'h81);
        start_char(8'h9A, 4'd7);
        cell_pixels(8'h81, 1, 3, "R9");
        host_we = 1'b1; host_addr = 16'h81A7; host_wdata = 8'h7E;
        cell_pixels(8'h81, 4, 12, "R9");
        exp_ram[12'h1A7] = 8'h7E;
        // R9: a fetch on the same edge as a write returns the old row
        start_char(8'h9A, 4'd7);
        host_we = 1'b1; host_addr = 16'h81A7; host_wdata = 8'h18;
        cell_pixels(8'h7E, 1, 12, "R9");
        start_char(8'h9A, 4'd7);
        cell_pixels(8'h18, 1, 12, "R9");

        @(negedge clk);
        check(pixel, 1'b0, "R6");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule